// File: doc/BRIEF.md
# Serial Register-Access Slave with Time-Update Freeze

This block is a serial slave port that gives a host access to a 64-location byte register space. The first eight locations are timekeeping registers, and the remaining locations are plain user memory. The host pulls the active-low select low and clocks a command byte in on the data input. The command byte holds a direction bit followed by a seven-bit start address. One or more data bytes follow. After each complete byte the internal pointer moves forward by one. When the pointer passes the top of the space it wraps to zero, so a burst can go on for as long as select stays low.

The timekeeping registers are user-visible copies of a set of live time counters that sit outside this block. On every system clock the block reloads the copies from a parallel input bus. While the pointer rests on a timekeeping location, the block holds off that reload and raises an inhibit output. This lets a multi-byte read see one consistent snapshot. A write to a timekeeping location also issues a one-cycle preset strobe, so the external counter takes the new value. A power-fail input makes the port behave as deselected.

All serial pins are resynchronised into the system clock domain, so the serial clock must be much slower than the system clock.

Top module: `sreg_port`

## Requirements
- R1: A transfer opens with a command byte, sent most-significant bit first on rising serial clock edges. Its first bit picks the direction: 1 means write and 0 means read. The next seven bits are the start address, and only the low six of them are used. For example, address 50h reaches location 10h.
- R2: In a write, a data byte is sampled on eight rising serial clock edges, MSB first. It is stored at the pointer only when its eighth bit arrives.
- R3: In a read, the byte at the pointer is driven MSB first. Each bit changes after a falling serial clock edge. The first bit appears after the falling edge that follows the eighth command bit.
- R4: While select stays low, each completed data byte advances the pointer by one. This holds in both directions.
- R5: The pointer wraps from 3Fh to 00h in both read and write bursts.
- R6: While a transfer is in its data phase and the pointer is in 00h–07h, `freeze` is high. This applies to both directions. The visible timekeeping registers then keep their values even if `live_time` changes.
- R7: `freeze` falls when select goes high, or when the pointer moves on to 08h.
- R8: While `freeze` is low, timekeeping register k follows byte k of `live_time`, where byte k is bits 8k+7 down to 8k.
- R9: A completed write to timekeeping location k pulses `preset_we` for one system clock, with `preset_idx` equal to k and `preset_data` equal to the byte. A write to user memory gives no pulse.
- R10: If select rises in the middle of a byte, that partial byte is discarded. Select rising also clears the bit count and command state, so the next transfer starts with a fresh command byte.
- R11: While `pwr_fail` is high, the port acts as deselected. Writes have no effect and `sdo_oe` stays low.
- R12: While select is high, `sdo_oe` is low and the data output is in high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low serial select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data input |
| pwr_fail | input | 1 | Power-fail condition; forces deselect |
| live_time | input | 64 | Eight live time counter bytes, byte k in bits 8k+7:8k |
| sdo | output | 1 | Serial data output value |
| sdo_oe | output | 1 | Output driver enable; 0 means high impedance |
| freeze | output | 1 | Inhibits updates to the visible time registers |
| preset_we | output | 1 | One-cycle strobe to preset a live counter |
| preset_idx | output | 3 | Index of the counter to preset |
| preset_data | output | 8 | Value to preset |

## Verification
Each serial pin passes through two synchroniser stages and one edge-detect register. A pointer move, a write, a change on `sdo` or a change on `freeze` therefore shows up on the ports three system clocks after the pin edge that causes it. A preset strobe is visible in the same cycle as the internal write. The bench holds each serial clock phase for eight system clocks and changes inputs on falling system clock edges. It reads `sdo` just before it raises the serial clock, which is five clocks after the data became valid. It checks `freeze` and the preset capture eight clocks after the edge that causes them. No check lands within the three-clock latency window.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
   typedef enum logic {
      PH_CMD  = 1'b0,
      PH_DATA = 1'b1
   } phase_t;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
   parameter int           STAGES  = 2,
   parameter int           W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d_i;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q_o = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sreg_shifter.sv
module sreg_shifter
   import sreg_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 6,
   parameter int CMD_ADDR_W = 7,
   parameter int CLK_REGS   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              sclk_s,
   input  logic              sdi_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] ptr,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              freeze
);
   localparam int CMD_LEN = 1 + CMD_ADDR_W;
   localparam int MAXLEN  = (CMD_LEN > DATA_W) ? CMD_LEN : DATA_W;
   localparam int CNT_W   = $clog2(MAXLEN);
   localparam logic [CNT_W-1:0]  CMD_LAST = CNT_W'(CMD_LEN - 1);
   localparam logic [CNT_W-1:0]  DAT_LAST = CNT_W'(DATA_W - 1);
   localparam logic [ADDR_W-1:0] CLK_LIM  = ADDR_W'(CLK_REGS);

   phase_t            phase;
   logic              is_wr;
   logic              sclk_q;
   logic              out_vld;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-2:0] in_sr;
   logic [DATA_W-1:0] out_sr;
   logic              rise, fall, byte_done;

   assign rise      = sclk_s & ~sclk_q;
   assign fall      = ~sclk_s & sclk_q;
   assign byte_done = active && rise && (phase == PH_DATA) && (bit_cnt == DAT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_CMD;
         is_wr   <= 1'b0;
         sclk_q  <= 1'b0;
         out_vld <= 1'b0;
         bit_cnt <= '0;
         in_sr   <= '0;
         out_sr  <= '0;
         ptr     <= '0;
      end else begin
         sclk_q <= sclk_s;
         if (!active) begin
            phase   <= PH_CMD;
            bit_cnt <= '0;
            out_vld <= 1'b0;
         end else begin
            if (rise) begin
               in_sr <= {in_sr[DATA_W-3:0], sdi_s};
               if (phase == PH_CMD) begin
                  if (bit_cnt == '0) is_wr <= sdi_s;
                  if (bit_cnt == CMD_LAST) begin
                     phase   <= PH_DATA;
                     bit_cnt <= '0;
                     ptr     <= {in_sr[ADDR_W-2:0], sdi_s};
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end else if (bit_cnt == DAT_LAST) begin
                  bit_cnt <= '0;
                  ptr     <= ptr + 1'b1;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
            if (fall && (phase == PH_DATA) && !is_wr) begin
               if (bit_cnt == '0) begin
                  out_sr  <= rd_data;
                  out_vld <= 1'b1;
               end else begin
                  out_sr <= {out_sr[DATA_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign wr_en   = byte_done && is_wr;
   assign wr_data = {in_sr, sdi_s};
   assign sdo     = out_sr[DATA_W-1];
   assign sdo_oe  = active && out_vld && (phase == PH_DATA) && !is_wr;
   assign freeze  = active && (phase == PH_DATA) && (ptr < CLK_LIM);

   // R4: a finished data byte moves the pointer by exactly one
   a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> ptr == $past(ptr) + 1'b1);
   // R5: pointer leaves the top location for location zero
   a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && (ptr == '1)) |=> (ptr == '0));
   // R10: dropping out of selection clears the transfer state
   a_r10_desel_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (phase == PH_CMD) && (bit_cnt == '0) && !out_vld);
endmodule

// File: rtl/sreg_regfile.sv
module sreg_regfile #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 6,
   parameter int CLK_REGS = 8,
   localparam int CIDX_W  = (CLK_REGS > 1) ? $clog2(CLK_REGS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       freeze,
   input  logic [CLK_REGS*DATA_W-1:0] live_time,
   output logic [DATA_W-1:0]          rd_data,
   output logic                       preset_we,
   output logic [CIDX_W-1:0]          preset_idx,
   output logic [DATA_W-1:0]          preset_data
);
   localparam int DEPTH     = 1 << ADDR_W;
   localparam int RAM_DEPTH = DEPTH - CLK_REGS;
   localparam logic [ADDR_W-1:0] CLK_LIM = ADDR_W'(CLK_REGS);

   logic [DATA_W-1:0] clk_q [CLK_REGS];
   logic [DATA_W-1:0] ram   [RAM_DEPTH];
   logic              in_clk;
   logic [ADDR_W-1:0] ram_idx;

   assign in_clk  = addr < CLK_LIM;
   assign ram_idx = addr - CLK_LIM;

   generate
      for (genvar k = 0; k < CLK_REGS; k++) begin : g_clk
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               clk_q[k] <= '0;
            else if (wr_en && (addr == ADDR_W'(k)))
               clk_q[k] <= wr_data;
            else if (!freeze)
               clk_q[k] <= live_time[k*DATA_W +: DATA_W];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en && !in_clk) ram[ram_idx] <= wr_data;
   end

   assign rd_data     = in_clk ? clk_q[CIDX_W'(addr)] : ram[ram_idx];
   assign preset_we   = wr_en && in_clk;
   assign preset_idx  = CIDX_W'(addr);
   assign preset_data = wr_data;

   // R6: a frozen register holds unless the host writes it
   generate
      for (genvar k = 0; k < CLK_REGS; k++) begin : g_hold
         a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (freeze && !(wr_en && (addr == ADDR_W'(k)))) |=> $stable(clk_q[k]));
      end
   endgenerate
endmodule

// File: rtl/sreg_port.sv
module sreg_port #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 6,
   parameter int CMD_ADDR_W  = 7,
   parameter int CLK_REGS    = 8,
   parameter int SYNC_STAGES = 2,
   localparam int CIDX_W     = (CLK_REGS > 1) ? $clog2(CLK_REGS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sel_n,
   input  logic                       sclk,
   input  logic                       sdi,
   input  logic                       pwr_fail,
   input  logic [CLK_REGS*DATA_W-1:0] live_time,
   output logic                       sdo,
   output logic                       sdo_oe,
   output logic                       freeze,
   output logic                       preset_we,
   output logic [CIDX_W-1:0]          preset_idx,
   output logic [DATA_W-1:0]          preset_data
);
   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("sreg_port: DATA_W must be at least 2");
      end
      if (ADDR_W < 2 || ADDR_W > CMD_ADDR_W || ADDR_W > DATA_W) begin : g_bad_addr
         $error("sreg_port: ADDR_W must fit the command address and data width");
      end
      if (CLK_REGS < 1 || CLK_REGS >= (1 << ADDR_W)) begin : g_bad_clk
         $error("sreg_port: CLK_REGS must leave room for user memory");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("sreg_port: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic              sel_n_s, sclk_s, sdi_s, active;
   logic [ADDR_W-1:0] ptr;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data, rd_data;

   sreg_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({sel_n, sclk, sdi}),
      .q_o   ({sel_n_s, sclk_s, sdi_s})
   );

   assign active = ~sel_n_s & ~pwr_fail;

   sreg_shifter #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CMD_ADDR_W(CMD_ADDR_W), .CLK_REGS(CLK_REGS)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .sclk_s  (sclk_s),
      .sdi_s   (sdi_s),
      .rd_data (rd_data),
      .ptr     (ptr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .sdo     (sdo),
      .sdo_oe  (sdo_oe),
      .freeze  (freeze)
   );

   sreg_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLK_REGS(CLK_REGS)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .addr        (ptr),
      .wr_data     (wr_data),
      .freeze      (freeze),
      .live_time   (live_time),
      .rd_data     (rd_data),
      .preset_we   (preset_we),
      .preset_idx  (preset_idx),
      .preset_data (preset_data)
   );

   // R9: a counter preset only happens while a clock location is held
   a_r9_preset_in_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      preset_we |-> freeze);
   // R11: power fail keeps the output driver off
   a_r11_pf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> !sdo_oe);
   // R12: with select held high past the sync delay the driver is off
   a_r12_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n && $past(sel_n) && $past(sel_n, 2) && $past(sel_n, 3)) |-> !sdo_oe);
endmodule

// File: tb/sim_sreg_port.sv
module sim_sreg_port;
   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_n = 1'b1;
   logic        sclk = 1'b0;
   logic        sdi = 1'b0;
   logic        pwr_fail = 1'b0;
   logic [63:0] live_time = 64'h0;
   logic        sdo, sdo_oe, freeze, preset_we;
   logic [2:0]  preset_idx;
   logic [7:0]  preset_data;

   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;
   int          pcnt = 0;
   logic [2:0]  pidx = '0;
   logic [7:0]  pdat = '0;

   always #10 clk = ~clk;

   sreg_port u0 (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
      .pwr_fail(pwr_fail), .live_time(live_time), .sdo(sdo), .sdo_oe(sdo_oe),
      .freeze(freeze), .preset_we(preset_we), .preset_idx(preset_idx),
      .preset_data(preset_data)
   );

   always @(posedge clk) begin
      if (preset_we) begin
         pcnt <= pcnt + 1;
         pidx <= preset_idx;
         pdat <= preset_data;
      end
   end

   // vector: [16] write flag, [15:8] address, [7:0] data
   localparam int NV = 10;
   localparam logic [16:0] VEC [NV] = '{
      {1'b1, 8'h10, 8'hA5}, {1'b1, 8'h3F, 8'h3C}, {1'b1, 8'h20, 8'h81},
      {1'b1, 8'h21, 8'h44}, {1'b0, 8'h10, 8'hA5}, {1'b0, 8'h3F, 8'h3C},
      {1'b0, 8'h20, 8'h81}, {1'b0, 8'h21, 8'h44}, {1'b1, 8'h50, 8'h77},
      {1'b0, 8'h10, 8'h77}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_io(input logic di, output logic dq);
      sdi = di;
      hold(HALF);
      dq = sdo;
      sclk = 1'b1;
      hold(HALF);
      sclk = 1'b0;
   endtask

   task automatic open_x();
      sel_n = 1'b0;
      hold(HALF);
   endtask

   task automatic close_x();
      hold(HALF);
      sel_n = 1'b1;
      hold(HALF);
   endtask

   task automatic cmd(input logic wr, input logic [6:0] a);
      logic [7:0] c;
      logic       dq;
      c = {wr, a};
      for (int i = 7; i >= 0; i--) bit_io(c[i], dq);
   endtask

   task automatic put(input logic [7:0] b);
      logic dq;
      for (int i = 7; i >= 0; i--) bit_io(b[i], dq);
   endtask

   task automatic get(output logic [7:0] b);
      logic dq;
      for (int i = 7; i >= 0; i--) begin
         bit_io(1'b0, dq);
         b[i] = dq;
      end
   endtask

   function automatic logic [7:0] lbyte(input logic [63:0] l, input int k);
      return l[k*8 +: 8];
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0]  b;
      logic [63:0] l1, l2;
      int          pc0;
      hold(4);
      rst_n = 1'b1;
      hold(4);
      // reset state (R12)
      chk("R12 reset oe", {31'd0, sdo_oe}, 32'd0);
      chk("R6 reset freeze", {31'd0, freeze}, 32'd0);
      chk("R9 reset preset", {31'd0, preset_we}, 32'd0);

      // R1 R2 R3: vector table of single-byte transfers
      for (int v = 0; v < NV; v++) begin
         open_x();
         cmd(VEC[v][16], VEC[v][14:8]);
         if (VEC[v][16]) begin
            put(VEC[v][7:0]);
         end else begin
            get(b);
            chk("R1 R2 R3 vector read", {24'd0, b}, {24'd0, VEC[v][7:0]});
         end
         close_x();
      end
      chk("R9 no preset on memory writes", pcnt, 0);

      // R12: idle select keeps driver off
      chk("R12 idle oe", {31'd0, sdo_oe}, 32'd0);

      // R8 R4: burst read of the tracked clock registers
      l1 = 64'h1716151413121110;
      live_time = l1;
      hold(4);
      open_x();
      cmd(1'b0, 7'h00);
      for (int k = 0; k < 8; k++) begin
         get(b);
         chk("R8 R4 clock burst", {24'd0, b}, {24'd0, lbyte(l1, k)});
      end
      close_x();

      // R6: freeze holds snapshot while live values move
      open_x();
      cmd(1'b0, 7'h02);
      chk("R6 freeze on clock addr", {31'd0, freeze}, 32'd1);
      l2 = 64'h9F8E7D6C5B4A3928;
      live_time = l2;
      get(b);
      chk("R6 frozen byte 2", {24'd0, b}, {24'd0, lbyte(l1, 2)});
      get(b);
      chk("R6 frozen byte 3", {24'd0, b}, {24'd0, lbyte(l1, 3)});
      close_x();
      chk("R7 release on deselect", {31'd0, freeze}, 32'd0);
      open_x();
      cmd(1'b0, 7'h02);
      get(b);
      chk("R8 tracks after release", {24'd0, b}, {24'd0, lbyte(l2, 2)});
      close_x();

      // R7: release when pointer moves to 08h
      open_x();
      cmd(1'b0, 7'h06);
      get(b);
      chk("R7 still frozen at 07", {31'd0, freeze}, 32'd1);
      get(b);
      chk("R7 released at 08", {31'd0, freeze}, 32'd0);
      close_x();

      // R6: freeze in write mode, R9 preset strobe
      pc0 = pcnt;
      open_x();
      cmd(1'b1, 7'h05);
      chk("R6 freeze in write", {31'd0, freeze}, 32'd1);
      put(8'h5A);
      close_x();
      chk("R9 preset count", pcnt, pc0 + 1);
      chk("R9 preset idx", {29'd0, pidx}, 32'd5);
      chk("R9 preset data", {24'd0, pdat}, 32'h5A);

      // R5: read wrap 3Fh -> 00h
      open_x();
      cmd(1'b0, 7'h3F);
      get(b);
      chk("R5 read at 3F", {24'd0, b}, 32'h3C);
      get(b);
      chk("R5 read wraps to 00", {24'd0, b}, {24'd0, lbyte(l2, 0)});
      close_x();

      // R5: write wrap 3Eh,3Fh,00h
      pc0 = pcnt;
      open_x();
      cmd(1'b1, 7'h3E);
      put(8'h11);
      put(8'h22);
      put(8'h33);
      close_x();
      chk("R5 write wrap preset count", pcnt, pc0 + 1);
      chk("R5 write wrap preset idx", {29'd0, pidx}, 32'd0);
      chk("R5 write wrap preset data", {24'd0, pdat}, 32'h33);
      open_x();
      cmd(1'b0, 7'h3E);
      get(b);
      chk("R5 R4 burst 3E", {24'd0, b}, 32'h11);
      get(b);
      chk("R5 R4 burst 3F", {24'd0, b}, 32'h22);
      close_x();

      // R10: partial byte discarded, fresh command afterwards
      open_x();
      cmd(1'b1, 7'h20);
      for (int i = 0; i < 5; i++) begin
         logic dq;
         bit_io(1'b1, dq);
      end
      close_x();
      open_x();
      cmd(1'b0, 7'h20);
      get(b);
      chk("R10 partial discarded", {24'd0, b}, 32'h81);
      close_x();

      // R11: power fail blocks writes and output
      pwr_fail = 1'b1;
      open_x();
      cmd(1'b1, 7'h21);
      put(8'hFF);
      close_x();
      open_x();
      cmd(1'b0, 7'h21);
      hold(HALF);
      chk("R11 oe low under power fail", {31'd0, sdo_oe}, 32'd0);
      close_x();
      pwr_fail = 1'b0;
      hold(4);
      open_x();
      cmd(1'b0, 7'h21);
      hold(HALF);
      chk("R3 oe on in read", {31'd0, sdo_oe}, 32'd1);
      get(b);
      chk("R11 write ignored", {24'd0, b}, 32'h44);
      close_x();
      chk("R12 oe off after deselect", {31'd0, sdo_oe}, 32'd0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule